// File: doc/BRIEF.md
# Critical-Section Aware Snooping MSI Line Controller

This block keeps the coherence state of every line of a private write-back cache attached to a shared snooping bus. On top of the usual Invalid, Shared and Modified states it has two more: a shared-in-critical-section state and a modified-in-critical-section state. A line enters one of these when a CPU miss finds that the block is also held in an isolation buffer. In these states, hits that would normally stay inside the core put a read or invalidation message on the bus. An isolation buffer elsewhere can then observe accesses it would otherwise miss.

Each cycle the controller takes at most one event. The event is either a CPU access (read or write, tag match or not, isolation-buffer indication) or a snooped bus request (read miss, write miss, invalidate) on one line. The controller looks up the line's state and computes the transition. One cycle later it presents registered outputs: the bus request to issue, a write-back strobe, the line index and the line's new state. Data arrays, bus arbitration and the isolation buffer are handled by the surrounding logic.

Top module: `coh_line_ctrl`

## Requirements
- R1: Reset is synchronous and active high. It makes every line Invalid and drives all outputs low. After reset, the first CPU read to any line is handled as a miss from Invalid.
- R2: Outputs are registered and appear in the cycle after the event clock edge, with `upd_vld` high for exactly that one cycle.
  - `upd_state` uses the encoding Invalid=0, Shared=1, Modified=2, CS-Shared=3, CS-Modified=4.
  - `upd_idx` echoes the line index.
  - At most one of the four bus request outputs is high, and none is high while `upd_vld` is low.
- R3: With the isolation indication low, a CPU miss follows plain MSI:
  - A read miss moves the line to Shared and raises `bus_rdmiss`.
  - A write miss moves the line to Modified and raises `bus_wrmiss`.
  - A miss is an access to an Invalid line or an access with `cpu_tag_hit` low.
- R4: With the isolation indication high, a CPU read miss moves the line to CS-Shared and raises `bus_rdmiss`. A CPU write miss moves it to CS-Modified and raises `bus_wrmiss`.
- R5: A miss that replaces a line in Modified or CS-Modified raises `wb` together with the miss request. Replacing a Shared, CS-Shared or Invalid line raises no `wb`.
- R6: On a Shared line:
  - A read hit issues nothing and stays Shared.
  - A write hit raises `bus_inv` and moves to Modified.
  - Read and write hits on a Modified line issue nothing and stay Modified.
- R7: On a CS-Shared line:
  - A read hit raises `bus_rd` and stays CS-Shared.
  - A write hit raises `bus_inv` and moves to CS-Modified.
- R8: On a CS-Modified line:
  - A read hit raises `bus_rd`.
  - A write hit raises `bus_inv`.
  - Both stay CS-Modified.
- R9: Snooped read miss (`snp_kind`=0) moves:
  - Modified to Shared, with `wb` and no request.
  - CS-Modified to CS-Shared, with `wb` and `bus_rd`.
  - Invalid, Shared and CS-Shared do not change, and no output fires.
- R10: Snooped write miss (`snp_kind`=1) moves every state to Invalid. `wb` is raised only when leaving Modified or CS-Modified.
- R11: Snooped invalidate (`snp_kind`=2) moves every state to Invalid. `wb` is raised only when leaving Modified or CS-Modified.
- R12: The isolation indication has no effect on hits or on snooped requests.
- R13: When a snoop and a CPU access arrive in the same cycle, the snoop is processed and the CPU access is dropped, leaving its line's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access valid this cycle |
| cpu_wr | input | 1 | CPU access is a write (0 = read) |
| cpu_tag_hit | input | 1 | Tag of the addressed line matches |
| cpu_iso_found | input | 1 | Accessed block is present in an isolation buffer |
| cpu_idx | input | IDX_W | Line index of the CPU access |
| snp_req | input | 1 | Snooped bus request valid this cycle |
| snp_kind | input | 2 | Snoop type: 0 read miss, 1 write miss, 2 invalidate |
| snp_idx | input | IDX_W | Line index of the snooped request |
| bus_rd | output | 1 | Issue bus read message |
| bus_rdmiss | output | 1 | Issue bus read miss |
| bus_wrmiss | output | 1 | Issue bus write miss |
| bus_inv | output | 1 | Issue bus invalidation |
| wb | output | 1 | Write back the line's block |
| upd_vld | output | 1 | An event was processed; outputs below are meaningful |
| upd_idx | output | IDX_W | Line index of the processed event |
| upd_state | output | 3 | New state of that line |

## Verification
The bench builds the controller with `LINES=4`, which makes every line reachable in a short run. On each line it drives each of the five states into place and then applies all eight CPU access combinations and all three snoop types. The 220 resulting transitions are compared against a table model in the bench. Further directed cases cover a reset in mid-run, the one-cycle width of the update pulse, and a snoop colliding with a CPU access on another line.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    ST_I   = 3'd0,
    ST_S   = 3'd1,
    ST_M   = 3'd2,
    ST_CSS = 3'd3,
    ST_CSM = 3'd4
  } line_st_t;

  localparam logic [1:0] SNP_RDMISS = 2'd0;
  localparam logic [1:0] SNP_WRMISS = 2'd1;
  localparam logic [1:0] SNP_INV    = 2'd2;

  typedef struct packed {
    logic rd;
    logic rdmiss;
    logic wrmiss;
    logic inv;
  } bus_req_t;
endpackage

// File: rtl/coh_next.sv
module coh_next
  import coh_pkg::*;
(
  input  line_st_t   cur,
  input  logic       is_snoop,
  input  logic [1:0] snp_kind,
  input  logic       cpu_wr,
  input  logic       tag_hit,
  input  logic       iso_found,
  output line_st_t   nxt,
  output bus_req_t   req,
  output logic       wb
);
  logic owned;
  logic hit;

  assign owned = (cur == ST_M) || (cur == ST_CSM);
  assign hit   = (cur != ST_I) && tag_hit;

  always_comb begin
    nxt = cur;
    req = '0;
    wb  = 1'b0;
    if (is_snoop) begin
      case (snp_kind)
        SNP_RDMISS: begin
          if (cur == ST_M) begin
            nxt = ST_S;
            wb  = 1'b1;
          end else if (cur == ST_CSM) begin
            nxt    = ST_CSS;
            wb     = 1'b1;
            req.rd = 1'b1;
          end
        end
        SNP_WRMISS, SNP_INV: begin
          nxt = ST_I;
          wb  = owned;
        end
        default: nxt = cur;
      endcase
    end else if (!hit) begin
      // miss: replacement of an owned line writes it back
      wb = owned;
      if (cpu_wr) begin
        nxt        = iso_found ? ST_CSM : ST_M;
        req.wrmiss = 1'b1;
      end else begin
        nxt        = iso_found ? ST_CSS : ST_S;
        req.rdmiss = 1'b1;
      end
    end else begin
      case (cur)
        ST_S: if (cpu_wr) begin
          nxt     = ST_M;
          req.inv = 1'b1;
        end
        ST_CSS: if (cpu_wr) begin
          nxt     = ST_CSM;
          req.inv = 1'b1;
        end else begin
          req.rd = 1'b1;
        end
        ST_CSM: if (cpu_wr) begin
          req.inv = 1'b1;
        end else begin
          req.rd = 1'b1;
        end
        default: nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/coh_state_store.sv
module coh_state_store
  import coh_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output line_st_t         rd_state,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_st_t         wr_state
);
  logic [LINES-1:0] vld_q;
  line_st_t         mem [LINES];

  // reset only clears the valid vector so the state array can map to RAM
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (we) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_state;
  end

  assign rd_state = vld_q[rd_idx] ? mem[rd_idx] : ST_I;

  assert_reset_invalid_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_state == ST_I));
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_req,
  input  logic             cpu_wr,
  input  logic             cpu_tag_hit,
  input  logic             cpu_iso_found,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             snp_req,
  input  logic [1:0]       snp_kind,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             bus_rd,
  output logic             bus_rdmiss,
  output logic             bus_wrmiss,
  output logic             bus_inv,
  output logic             wb,
  output logic             upd_vld,
  output logic [IDX_W-1:0] upd_idx,
  output logic [2:0]       upd_state
);
  logic             ev;
  logic [IDX_W-1:0] ev_idx;
  line_st_t         cur_st;
  line_st_t         nxt_st;
  line_st_t         prev_st_q;
  bus_req_t         req;
  logic             wb_c;

  // snoop wins; a colliding CPU access is dropped
  assign ev     = snp_req || cpu_req;
  assign ev_idx = snp_req ? snp_idx : cpu_idx;

  coh_state_store #(.LINES(LINES)) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (ev_idx),
    .rd_state (cur_st),
    .we       (ev),
    .wr_idx   (ev_idx),
    .wr_state (nxt_st)
  );

  coh_next u_next (
    .cur       (cur_st),
    .is_snoop  (snp_req),
    .snp_kind  (snp_kind),
    .cpu_wr    (cpu_wr),
    .tag_hit   (cpu_tag_hit),
    .iso_found (cpu_iso_found),
    .nxt       (nxt_st),
    .req       (req),
    .wb        (wb_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd     <= 1'b0;
      bus_rdmiss <= 1'b0;
      bus_wrmiss <= 1'b0;
      bus_inv    <= 1'b0;
      wb         <= 1'b0;
      upd_vld    <= 1'b0;
      upd_idx    <= '0;
      upd_state  <= ST_I;
      prev_st_q  <= ST_I;
    end else begin
      bus_rd     <= ev && req.rd;
      bus_rdmiss <= ev && req.rdmiss;
      bus_wrmiss <= ev && req.wrmiss;
      bus_inv    <= ev && req.inv;
      wb         <= ev && wb_c;
      upd_vld    <= ev;
      upd_idx    <= ev_idx;
      upd_state  <= nxt_st;
      prev_st_q  <= cur_st;
    end
  end

  assert_req_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_rd, bus_rdmiss, bus_wrmiss, bus_inv}));

  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !upd_vld |-> !(bus_rd || bus_rdmiss || bus_wrmiss || bus_inv || wb));

  assert_rdmiss_target_R3: assert property (@(posedge clk) disable iff (rst)
    bus_rdmiss |-> (upd_state == ST_S || upd_state == ST_CSS));

  assert_wrmiss_target_R4: assert property (@(posedge clk) disable iff (rst)
    bus_wrmiss |-> (upd_state == ST_M || upd_state == ST_CSM));

  assert_wb_owner_R5: assert property (@(posedge clk) disable iff (rst)
    wb |-> (prev_st_q == ST_M || prev_st_q == ST_CSM));

  assert_rdmsg_cs_R7: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> ((prev_st_q == ST_CSS || prev_st_q == ST_CSM) &&
                (upd_state == ST_CSS || upd_state == ST_CSM)));

  assert_inv_upgrade_R6: assert property (@(posedge clk) disable iff (rst)
    bus_inv |-> ((upd_state == ST_M || upd_state == ST_CSM) && prev_st_q != ST_M));
endmodule

// File: tb/coh_line_ctrl_test.sv
`timescale 1ns/1ps
module coh_line_ctrl_test;
  localparam int LINES = 4;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_wr = 1'b0, cpu_tag_hit = 1'b0, cpu_iso_found = 1'b0;
  logic [IDX_W-1:0] cpu_idx = '0;
  logic snp_req = 1'b0;
  logic [1:0] snp_kind = 2'd0;
  logic [IDX_W-1:0] snp_idx = '0;
  logic bus_rd, bus_rdmiss, bus_wrmiss, bus_inv, wb, upd_vld;
  logic [IDX_W-1:0] upd_idx;
  logic [2:0] upd_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  coh_line_ctrl #(.LINES(LINES)) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .cpu_tag_hit(cpu_tag_hit), .cpu_iso_found(cpu_iso_found), .cpu_idx(cpu_idx),
    .snp_req(snp_req), .snp_kind(snp_kind), .snp_idx(snp_idx),
    .bus_rd(bus_rd), .bus_rdmiss(bus_rdmiss), .bus_wrmiss(bus_wrmiss),
    .bus_inv(bus_inv), .wb(wb), .upd_vld(upd_vld), .upd_idx(upd_idx),
    .upd_state(upd_state)
  );

  // {vld, idx[1:0], state[2:0], rd, rdmiss, wrmiss, inv, wb}
  function automatic logic [10:0] observed();
    return {upd_vld, upd_idx, upd_state, bus_rd, bus_rdmiss, bus_wrmiss, bus_inv, wb};
  endfunction

  task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // expected transition computed from the requirement table
  function automatic logic [7:0] model(input int st, input bit snoop, input int kind,
                                       input bit wr, input bit th, input bit iso,
                                       output string tag);
    int ns; bit rd, rm, wm, iv, w;
    bit own;
    own = (st == 2) || (st == 4);
    ns = st; rd = 0; rm = 0; wm = 0; iv = 0; w = 0;
    if (snoop) begin
      if (kind == 0) begin
        tag = "R9/R12";
        if (st == 2) begin ns = 1; w = 1; end
        else if (st == 4) begin ns = 3; w = 1; rd = 1; end
      end else begin
        tag = (kind == 1) ? "R10/R12" : "R11/R12";
        ns = 0; w = own;
      end
    end else if (st == 0 || !th) begin
      tag = iso ? "R4/R5" : "R3/R5";
      w = own;
      if (wr) begin wm = 1; ns = iso ? 4 : 2; end
      else    begin rm = 1; ns = iso ? 3 : 1; end
    end else begin
      case (st)
        1: begin tag = "R6/R12"; if (wr) begin ns = 2; iv = 1; end end
        2: tag = "R6/R12";
        3: begin tag = "R7/R12"; if (wr) begin ns = 4; iv = 1; end else rd = 1; end
        default: begin tag = "R8/R12"; if (wr) iv = 1; else rd = 1; end
      endcase
    end
    return {ns[2:0], rd, rm, wm, iv, w};
  endfunction

  task automatic drive(input bit sreq, input int kind, input int sidx,
                       input bit creq, input bit wr, input bit th, input bit iso, input int cidx);
    @(negedge clk);
    snp_req = sreq; snp_kind = kind[1:0]; snp_idx = sidx[IDX_W-1:0];
    cpu_req = creq; cpu_wr = wr; cpu_tag_hit = th; cpu_iso_found = iso;
    cpu_idx = cidx[IDX_W-1:0];
    @(negedge clk);
    snp_req = 1'b0; cpu_req = 1'b0;
  endtask

  task automatic put_state(input int line, input int st);
    drive(1, 1, line, 0, 0, 0, 0, 0);
    case (st)
      1: drive(0, 0, 0, 1, 0, 0, 0, line);
      2: drive(0, 0, 0, 1, 1, 0, 0, line);
      3: drive(0, 0, 0, 1, 0, 0, 1, line);
      4: drive(0, 0, 0, 1, 1, 0, 1, line);
      default: ;
    endcase
  endtask

  initial begin
    string tag;
    logic [7:0] e;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset state
    check("R1 reset outputs", observed(), 11'd0);
    rst = 1'b0;
    // R1: every line reads as Invalid after reset
    for (int l = 0; l < LINES; l++) begin
      drive(0, 0, 0, 1, 0, 1, 0, l);
      check("R1 first read misses", observed(), {1'b1, l[1:0], 3'd1, 5'b01000});
      // R2: update pulse lasts one cycle
      @(negedge clk);
      check("R2 pulse width", {upd_vld, 10'd0}, 11'd0);
    end
    // R2 plus all transition requirements: exhaustive sweep
    for (int l = 0; l < LINES; l++)
      for (int s = 0; s < 5; s++)
        for (int ev = 0; ev < 11; ev++) begin
          put_state(l, s);
          if (ev < 8) begin
            e = model(s, 0, 0, ev[0], ev[1], ev[2], tag);
            drive(0, 0, 0, 1, ev[0], ev[1], ev[2], l);
          end else begin
            e = model(s, 1, ev - 8, 0, 0, 1, tag);
            // CPU-side inputs held non-idle but cpu_req low (R12)
            drive(1, ev - 8, l, 0, 1, 1, 1, 0);
          end
          check(tag, observed(), {1'b1, l[1:0], e});
        end
    // R13: snoop on line 0 collides with a CPU write miss on line 1
    put_state(0, 1);
    put_state(1, 0);
    drive(1, 2, 0, 1, 1, 0, 0, 1);
    check("R13 snoop wins", observed(), {1'b1, 2'd0, 3'd0, 5'b00000});
    drive(0, 0, 0, 1, 0, 1, 0, 1);
    check("R13 cpu dropped", observed(), {1'b1, 2'd1, 3'd1, 5'b01000});
    // R1: reset in mid-run returns an owned line to Invalid
    put_state(2, 2);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mid-run reset outputs", observed(), 11'd0);
    drive(0, 0, 0, 1, 0, 1, 0, 2);
    check("R1 line invalid after reset", observed(), {1'b1, 2'd2, 3'd1, 5'b01000});
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule